// File: doc/BRIEF.md
# Configurable TDM Serial Receiver

This block takes a time-division-multiplexed serial stream made of a bit clock, a frame sync and a single data line, all oversampled by the system clock. It cuts each frame into equal channel slots and delivers the sample of every enabled channel as one write, tagged with its channel number and a buffer offset. All channels share that offset, so a memory subsystem places each channel's sample at the same position relative to that channel's own buffer base.

The frame format is configurable. The sampling edge of the bit clock, the active level of the frame sync, a delay of zero to three bit periods between the sync and the first data bit, the bit order within a slot, the slot width (2, 4, 8 or 16 bits) and the channel count can all be set, and each channel can be enabled or disabled. The shared offset steps once per completed frame and wraps at a programmable buffer length. Two threshold comparators on the offset produce interrupt pulses, which lets software run a double-buffered scheme. Configuration inputs are expected to change only while reset is held.

Top module: `tdm_rx`

## Requirements
- R1: With `cfg_fall_edge` = 0 the sync and data lines are sampled on rising edges of `sclk`; with 1 they are sampled on falling edges.
- R2: With `cfg_sync_low` = 0 the sync is active high, and with 1 it is active low. A frame is triggered at the first sample edge where the sync is active after a sample where it was inactive.
- R3: Bit 0 of slot 0 is the data bit sampled `cfg_sync_dly` sample edges after the triggering edge, where `cfg_sync_dly` is 0 to 3. With 0 it is the bit sampled at the triggering edge itself.
- R4: With `cfg_lsb_first` = 0 the first bit of a slot is the most significant bit of the sample; with 1 it is the least significant bit.
- R5: `cfg_word_sel` values 0, 1, 2 and 3 select slots of 2, 4, 8 and 16 bits. Slots follow each other without gaps, and each sample appears zero-extended in the low bits of `wr_data`.
- R6: A frame holds `cfg_last_chan`+1 slots (up to 256). Slot n belongs to channel n, and its write carries `wr_chan` = n.
- R7: A channel whose `chan_active` bit is 0 produces no write, but its slot still takes up its time in the frame.
- R8: Every write of a frame carries the same `wr_offset`. The offset is 0 after reset and advances by one after the last slot of each complete frame.
- R9: The offset returns to 0 when an advance would reach `cfg_buf_words`; a value of 0 there lets it run over the full counter range.
- R10: `irq_a` and `irq_b` each pulse high for exactly one clock when the offset advances to `cfg_thr_a` and `cfg_thr_b` respectively.
- R11: While reset is held, `wr_en`, `irq_a`, `irq_b` and `wr_offset` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least six times the bit rate |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk | input | 1 | Serial bit clock |
| fsync | input | 1 | Frame sync |
| sdata | input | 1 | Serial data |
| cfg_fall_edge | input | 1 | 1: sample on falling sclk edges |
| cfg_sync_low | input | 1 | 1: frame sync is active low |
| cfg_sync_dly | input | 2 | Bit periods from sync to first data bit |
| cfg_lsb_first | input | 1 | 1: least significant bit first |
| cfg_word_sel | input | 2 | Slot width code (2/4/8/16 bits) |
| cfg_last_chan | input | CH_W | Number of channels minus one |
| chan_active | input | 2**CH_W | Per-channel enable |
| cfg_buf_words | input | OFS_W | Buffer length in words for wrap |
| cfg_thr_a | input | OFS_W | First offset threshold |
| cfg_thr_b | input | OFS_W | Second offset threshold |
| wr_en | output | 1 | Sample write strobe |
| wr_chan | output | CH_W | Channel of the write |
| wr_offset | output | OFS_W | Shared buffer offset of the write |
| wr_data | output | 16 | Received sample, zero-extended |
| irq_a | output | 1 | First threshold pulse |
| irq_b | output | 1 | Second threshold pulse |

## Verification
The main sweep covers every combination of sampling edge, sync polarity, sync delay, bit order and slot width on a four-channel frame, using random samples and an enable mask that changes from one configuration to the next. A wrong edge or polarity shifts or loses frames, a wrong delay or bit order corrupts the sample values, and a wrong mask shows up as extra or missing writes. A single frame of 256 two-bit channels checks the full channel range and the slot count. A run of seven one-channel frames into a three-word buffer checks offset wrap and the number and width of the threshold pulses, including a threshold of zero that is reached only through the wrap.

// File: rtl/tdm_rx_pkg.sv
// Shared types and helpers for the TDM receiver.
// Assumes samples are at most 16 bits wide.
package tdm_rx_pkg;

    localparam int SAMPLE_W = 16;
    localparam int BITCNT_W = 4;

    typedef enum logic [1:0] {
        WSEL_2  = 2'd0,
        WSEL_4  = 2'd1,
        WSEL_8  = 2'd2,
        WSEL_16 = 2'd3
    } wsel_t;

    // Slot length minus one for a width code.
    function automatic logic [BITCNT_W-1:0] last_bit_idx(input logic [1:0] sel);
        case (wsel_t'(sel))
            WSEL_2:  last_bit_idx = 4'd1;
            WSEL_4:  last_bit_idx = 4'd3;
            WSEL_8:  last_bit_idx = 4'd7;
            default: last_bit_idx = 4'd15;
        endcase
    endfunction

    // Mask that keeps the valid low bits of a sample.
    function automatic logic [SAMPLE_W-1:0] sample_mask(input logic [1:0] sel);
        case (wsel_t'(sel))
            WSEL_2:  sample_mask = 16'h0003;
            WSEL_4:  sample_mask = 16'h000F;
            WSEL_8:  sample_mask = 16'h00FF;
            default: sample_mask = 16'hFFFF;
        endcase
    endfunction

endpackage

// File: rtl/tdm_rx_sampler.sv
// Brings the serial lines into the clk domain and marks the selected
// sampling edge of the bit clock with a one-cycle tick.
// Assumes the bit clock is slower than clk / 4 and that data and sync
// are stable around the sampling edge.
module tdm_rx_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic fsync,
    input  logic sdata,
    input  logic cfg_fall_edge,
    input  logic cfg_sync_low,
    output logic tick,
    output logic sync_act,
    output logic dbit
);

    localparam int LINES = 3;

    logic [LINES-1:0] raw;
    logic [LINES-1:0] synced;
    logic             clk_prev;

    assign raw = {sdata, fsync, sclk};

    // One synchronizer chain per serial line.
    for (genvar g = 0; g < LINES; g++) begin : g_sync
        logic [SYNC_STAGES-1:0] chain;
        // Shift the line through its synchronizer chain.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[SYNC_STAGES-2:0], raw[g]};
        end
        assign synced[g] = chain[SYNC_STAGES-1];
    end

    // Remember the previous synchronized bit clock level.
    always_ff @(posedge clk) begin
        if (!rst_n) clk_prev <= 1'b0;
        else        clk_prev <= synced[0];
    end

    assign tick     = cfg_fall_edge ? (clk_prev & ~synced[0]) : (~clk_prev & synced[0]);
    assign sync_act = synced[1] ^ cfg_sync_low;
    assign dbit     = synced[2];

endmodule

// File: rtl/tdm_rx_framer.sv
// Tracks frame position: detects the sync, waits the programmed delay,
// then counts bits within a slot and slots within a frame.
// Assumes a new sync may be armed while a frame is still running.
module tdm_rx_framer
    import tdm_rx_pkg::*;
#(
    parameter int CH_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                sync_act,
    input  logic [1:0]          cfg_sync_dly,
    input  logic [1:0]          cfg_word_sel,
    input  logic [CH_W-1:0]     cfg_last_chan,
    output logic                bit_take,
    output logic                bit_first,
    output logic                slot_done,
    output logic                frame_done,
    output logic [CH_W-1:0]     slot_chan
);

    logic                sync_prev;
    logic                armed;
    logic [1:0]          dly_cnt;
    logic                running;
    logic [BITCNT_W-1:0] bit_cnt;
    logic [CH_W-1:0]     ch_cnt;

    logic                sync_edge;
    logic                start_now;
    logic [BITCNT_W-1:0] cur_bit;
    logic                last_bit;
    logic                last_ch;

    // Classify the current tick: trigger, frame start and slot position.
    always_comb begin
        sync_edge  = tick & sync_act & ~sync_prev;
        start_now  = (sync_edge & (cfg_sync_dly == 2'd0))
                   | (tick & armed & (dly_cnt == 2'd1));
        bit_take   = start_now | (tick & running);
        cur_bit    = start_now ? '0 : bit_cnt;
        slot_chan  = start_now ? '0 : ch_cnt;
        bit_first  = (cur_bit == '0);
        last_bit   = (cur_bit == last_bit_idx(cfg_word_sel));
        last_ch    = (slot_chan == cfg_last_chan);
        slot_done  = bit_take & last_bit;
        frame_done = slot_done & last_ch;
    end

    // Track the sync level seen at the previous sampling edge.
    always_ff @(posedge clk) begin
        if (!rst_n)    sync_prev <= 1'b0;
        else if (tick) sync_prev <= sync_act;
    end

    // Count down the sync-to-frame delay.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed   <= 1'b0;
            dly_cnt <= 2'd0;
        end else if (sync_edge && cfg_sync_dly != 2'd0) begin
            armed   <= 1'b1;
            dly_cnt <= cfg_sync_dly;
        end else if (tick && armed) begin
            if (dly_cnt == 2'd1) armed <= 1'b0;
            dly_cnt <= dly_cnt - 2'd1;
        end
    end

    // Advance bit and channel counters on each consumed bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            bit_cnt <= '0;
            ch_cnt  <= '0;
        end else if (bit_take) begin
            if (last_bit) begin
                bit_cnt <= '0;
                if (last_ch) begin
                    running <= 1'b0;
                    ch_cnt  <= '0;
                end else begin
                    running <= 1'b1;
                    ch_cnt  <= slot_chan + 1'b1;
                end
            end else begin
                running <= 1'b1;
                bit_cnt <= cur_bit + 1'b1;
                ch_cnt  <= slot_chan;
            end
        end
    end

endmodule

// File: rtl/tdm_rx_deser.sv
// Assembles slot bits into a sample in either bit order.
// Assumes bit_first marks the first bit of every slot.
module tdm_rx_deser
    import tdm_rx_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bit_take,
    input  logic                bit_first,
    input  logic                dbit,
    input  logic                cfg_lsb_first,
    input  logic [1:0]          cfg_word_sel,
    output logic [SAMPLE_W-1:0] sample
);

    logic [SAMPLE_W-1:0] shreg;
    logic [SAMPLE_W-1:0] base;
    logic [SAMPLE_W-1:0] nxt;
    logic [4:0]          align;

    // Form the shift register value including the current bit.
    always_comb begin
        base  = bit_first ? '0 : shreg;
        align = 5'd15 - {1'b0, last_bit_idx(cfg_word_sel)};
        if (cfg_lsb_first) begin
            nxt    = {dbit, base[SAMPLE_W-1:1]};
            sample = nxt >> align;
        end else begin
            nxt    = {base[SAMPLE_W-2:0], dbit};
            sample = nxt & sample_mask(cfg_word_sel);
        end
    end

    // Hold the partial sample between bits.
    always_ff @(posedge clk) begin
        if (!rst_n)        shreg <= '0;
        else if (bit_take) shreg <= nxt;
    end

endmodule

// File: rtl/tdm_rx_offset.sv
// Shared buffer offset with programmable wrap and threshold pulses.
// Assumes advances are at least two cycles apart.
module tdm_rx_offset #(
    parameter int OFS_W = 16,
    parameter int N_THR = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        advance,
    input  logic [OFS_W-1:0]            cfg_buf_words,
    input  logic [N_THR-1:0][OFS_W-1:0] thr,
    output logic [OFS_W-1:0]            ofs,
    output logic [N_THR-1:0]            hit
);

    logic [OFS_W-1:0] inc;
    logic [OFS_W-1:0] ofs_nxt;

    // Next offset with wrap at the buffer length.
    always_comb begin
        inc     = ofs + 1'b1;
        ofs_nxt = (inc == cfg_buf_words) ? '0 : inc;
    end

    // Step the offset once per completed frame.
    always_ff @(posedge clk) begin
        if (!rst_n)       ofs <= '0;
        else if (advance) ofs <= ofs_nxt;
    end

    // One comparator and pulse register per threshold.
    for (genvar t = 0; t < N_THR; t++) begin : g_thr
        // Pulse when the offset lands on this threshold.
        always_ff @(posedge clk) begin
            if (!rst_n) hit[t] <= 1'b0;
            else        hit[t] <= advance && (ofs_nxt == thr[t]);
        end
    end

endmodule

// File: rtl/tdm_rx.sv
// TDM serial receiver top: samples the serial stream, splits frames
// into slots and issues one write per enabled channel at the shared
// offset. Assumes configuration changes only while reset is held.
module tdm_rx
    import tdm_rx_pkg::*;
#(
    parameter  int CH_W   = 8,
    parameter  int OFS_W  = 16,
    localparam int NUM_CH = 1 << CH_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sclk,
    input  logic                fsync,
    input  logic                sdata,
    input  logic                cfg_fall_edge,
    input  logic                cfg_sync_low,
    input  logic [1:0]          cfg_sync_dly,
    input  logic                cfg_lsb_first,
    input  logic [1:0]          cfg_word_sel,
    input  logic [CH_W-1:0]     cfg_last_chan,
    input  logic [NUM_CH-1:0]   chan_active,
    input  logic [OFS_W-1:0]    cfg_buf_words,
    input  logic [OFS_W-1:0]    cfg_thr_a,
    input  logic [OFS_W-1:0]    cfg_thr_b,
    output logic                wr_en,
    output logic [CH_W-1:0]     wr_chan,
    output logic [OFS_W-1:0]    wr_offset,
    output logic [SAMPLE_W-1:0] wr_data,
    output logic                irq_a,
    output logic                irq_b
);

    localparam int N_THR = 2;

    logic                        tick;
    logic                        sync_act;
    logic                        dbit;
    logic                        bit_take;
    logic                        bit_first;
    logic                        slot_done;
    logic                        frame_done;
    logic [CH_W-1:0]             slot_chan;
    logic [SAMPLE_W-1:0]         sample;
    logic [OFS_W-1:0]            ofs_cur;
    logic [N_THR-1:0]            thr_hit;
    logic [N_THR-1:0][OFS_W-1:0] thr_vec;

    assign thr_vec = {cfg_thr_b, cfg_thr_a};

    tdm_rx_sampler #(.SYNC_STAGES(2)) u_sampler (
        .clk           (clk),
        .rst_n         (rst_n),
        .sclk          (sclk),
        .fsync         (fsync),
        .sdata         (sdata),
        .cfg_fall_edge (cfg_fall_edge),
        .cfg_sync_low  (cfg_sync_low),
        .tick          (tick),
        .sync_act      (sync_act),
        .dbit          (dbit)
    );

    tdm_rx_framer #(.CH_W(CH_W)) u_framer (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick          (tick),
        .sync_act      (sync_act),
        .cfg_sync_dly  (cfg_sync_dly),
        .cfg_word_sel  (cfg_word_sel),
        .cfg_last_chan (cfg_last_chan),
        .bit_take      (bit_take),
        .bit_first     (bit_first),
        .slot_done     (slot_done),
        .frame_done    (frame_done),
        .slot_chan     (slot_chan)
    );

    tdm_rx_deser u_deser (
        .clk           (clk),
        .rst_n         (rst_n),
        .bit_take      (bit_take),
        .bit_first     (bit_first),
        .dbit          (dbit),
        .cfg_lsb_first (cfg_lsb_first),
        .cfg_word_sel  (cfg_word_sel),
        .sample        (sample)
    );

    tdm_rx_offset #(.OFS_W(OFS_W), .N_THR(N_THR)) u_offset (
        .clk           (clk),
        .rst_n         (rst_n),
        .advance       (frame_done),
        .cfg_buf_words (cfg_buf_words),
        .thr           (thr_vec),
        .ofs           (ofs_cur),
        .hit           (thr_hit)
    );

    // Register the write for an enabled channel at the end of its slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en     <= 1'b0;
            wr_chan   <= '0;
            wr_offset <= '0;
            wr_data   <= '0;
        end else begin
            wr_en <= slot_done & chan_active[slot_chan];
            if (slot_done) begin
                wr_chan   <= slot_chan;
                wr_offset <= ofs_cur;
                wr_data   <= sample;
            end
        end
    end

    assign irq_a = thr_hit[0];
    assign irq_b = thr_hit[1];

endmodule

// File: rtl/tdm_rx_chk.sv
// Property checker for the TDM receiver, attached by bind.
// Assumes configuration is stable outside reset.
module tdm_rx_chk
    import tdm_rx_pkg::*;
#(
    parameter int CH_W  = 8,
    parameter int OFS_W = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic [1:0]          cfg_word_sel,
    input logic [CH_W-1:0]     cfg_last_chan,
    input logic [OFS_W-1:0]    cfg_buf_words,
    input logic [OFS_W-1:0]    cfg_thr_a,
    input logic [OFS_W-1:0]    cfg_thr_b,
    input logic                wr_en,
    input logic [CH_W-1:0]     wr_chan,
    input logic [SAMPLE_W-1:0] wr_data,
    input logic [OFS_W-1:0]    ofs_cur,
    input logic                irq_a,
    input logic                irq_b
);

    AST_DATA_FITS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ((wr_data & ~sample_mask(cfg_word_sel)) == '0)); // R5

    AST_CHAN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_chan <= cfg_last_chan)); // R6

    AST_OFS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ofs_cur) |-> (ofs_cur == $past(ofs_cur) + 1'b1 || ofs_cur == '0)); // R8

    AST_OFS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_buf_words != '0) |-> (ofs_cur < cfg_buf_words)); // R9

    AST_IRQA_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        irq_a |-> (ofs_cur == cfg_thr_a)); // R10

    AST_IRQB_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        irq_b |-> (ofs_cur == cfg_thr_b)); // R10

    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_a || irq_b) |=> !(irq_a && $past(irq_a)) && !(irq_b && $past(irq_b))); // R10

endmodule

bind tdm_rx tdm_rx_chk #(.CH_W(CH_W), .OFS_W(OFS_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_word_sel  (cfg_word_sel),
    .cfg_last_chan (cfg_last_chan),
    .cfg_buf_words (cfg_buf_words),
    .cfg_thr_a     (cfg_thr_a),
    .cfg_thr_b     (cfg_thr_b),
    .wr_en         (wr_en),
    .wr_chan       (wr_chan),
    .wr_data       (wr_data),
    .ofs_cur       (ofs_cur),
    .irq_a         (irq_a),
    .irq_b         (irq_b)
);

// File: tb/tdm_rx_test.sv
module tdm_rx_test;

    localparam int CH_W  = 8;
    localparam int OFS_W = 16;
    localparam int NCH   = 1 << CH_W;
    localparam int QMAX  = 600;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sclk = 1'b0, fsync = 1'b0, sdata = 1'b0;
    logic              cfg_fall_edge = 1'b0, cfg_sync_low = 1'b0, cfg_lsb_first = 1'b0;
    logic [1:0]        cfg_sync_dly = 2'd0, cfg_word_sel = 2'd0;
    logic [CH_W-1:0]   cfg_last_chan = '0;
    logic [NCH-1:0]    chan_active = '0;
    logic [OFS_W-1:0]  cfg_buf_words = '0, cfg_thr_a = 16'd100, cfg_thr_b = 16'd200;
    logic              wr_en, irq_a, irq_b;
    logic [CH_W-1:0]   wr_chan;
    logic [OFS_W-1:0]  wr_offset;
    logic [15:0]       wr_data;

    int total = 0, bad = 0;
    int mon_n = 0, irqa_n = 0, irqb_n = 0;
    int mon_ch [QMAX], mon_of [QMAX], mon_dt [QMAX];
    int exp_n = 0;
    int exp_ch [QMAX], exp_of [QMAX], exp_dt [QMAX];
    logic [15:0] val [NCH];
    int wl;
    bit done = 0;

    always #4 clk = ~clk;

    tdm_rx #(.CH_W(CH_W), .OFS_W(OFS_W)) uut (.*);

    // Record every write and count threshold pulse cycles.
    always @(negedge clk) begin
        if (rst_n && wr_en && mon_n < QMAX) begin
            mon_ch[mon_n] = wr_chan;
            mon_of[mon_n] = wr_offset;
            mon_dt[mon_n] = wr_data;
            mon_n++;
        end
        if (rst_n && irq_a) irqa_n++;
        if (rst_n && irq_b) irqb_n++;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic send_bit(input bit s_act, input bit d);
        if (!cfg_fall_edge) begin
            sclk = 1'b0; fsync = s_act ^ cfg_sync_low; sdata = d;
            repeat (3) @(negedge clk);
            sclk = 1'b1;
            repeat (3) @(negedge clk);
        end else begin
            sclk = 1'b1; fsync = s_act ^ cfg_sync_low; sdata = d;
            repeat (3) @(negedge clk);
            sclk = 1'b0;
            repeat (3) @(negedge clk);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        sclk  = cfg_fall_edge;
        fsync = cfg_sync_low;
        sdata = 1'b0;
        wl    = 2 << cfg_word_sel;
        repeat (4) @(negedge clk);
        mon_n = 0; irqa_n = 0; irqb_n = 0; exp_n = 0;
        rst_n = 1'b1;
        send_bit(0, 0);
        send_bit(0, 0);
    endtask

    // Pick samples for nch channels and queue the expected writes.
    task automatic load_frame(input int nch, input int ofs);
        for (int c = 0; c < nch; c++) begin
            val[c] = 16'($urandom) & 16'((1 << wl) - 1);
            if (chan_active[c] && exp_n < QMAX) begin
                exp_ch[exp_n] = c;
                exp_of[exp_n] = ofs;
                exp_dt[exp_n] = val[c];
                exp_n++;
            end
        end
    endtask

    // Serialize one frame: sync, delay, then slots in the chosen order.
    task automatic send_frame(input int nch);
        int nbits;
        nbits = cfg_sync_dly + nch * wl;
        for (int i = 0; i < nbits; i++) begin
            bit b;
            int j, c, k;
            b = 0;
            if (i >= cfg_sync_dly) begin
                j = i - cfg_sync_dly;
                c = j / wl;
                k = j % wl;
                b = cfg_lsb_first ? val[c][k] : val[c][wl-1-k];
            end
            send_bit(i == 0, b);
        end
        send_bit(0, 0);
        send_bit(0, 0);
    endtask

    task automatic compare(input string dtag);
        int n;
        repeat (4) @(negedge clk);
        chk(mon_n == exp_n, "R7 write count", mon_n, exp_n);
        n = (mon_n < exp_n) ? mon_n : exp_n;
        for (int i = 0; i < n; i++) begin
            chk(mon_ch[i] == exp_ch[i], "R6 channel", mon_ch[i], exp_ch[i]);
            chk(mon_of[i] == exp_of[i], "R8 offset", mon_of[i], exp_of[i]);
            chk(mon_dt[i] == exp_dt[i], dtag, mon_dt[i], exp_dt[i]);
        end
    endtask

    initial begin
        // R11: outputs during reset
        repeat (3) @(negedge clk);
        chk(wr_en == 1'b0, "R11 wr_en", wr_en, 0);
        chk(irq_a == 1'b0 && irq_b == 1'b0, "R11 irq", {irq_b, irq_a}, 0);
        chk(wr_offset == '0, "R11 offset", wr_offset, 0);

        // Sweep of R1 R2 R3 R4 R5 with R7 masks on four channels.
        for (int idx = 0; idx < 128; idx++) begin
            cfg_fall_edge = idx[0];
            cfg_sync_low  = idx[1];
            cfg_sync_dly  = 2'(idx >> 2);
            cfg_lsb_first = idx[4];
            cfg_word_sel  = 2'(idx >> 5);
            cfg_last_chan = 8'd3;
            cfg_buf_words = '0;
            chan_active   = '0;
            chan_active[3:0] = 4'((idx * 5 + 3) & 15);
            do_reset();
            load_frame(4, 0);
            send_frame(4);
            load_frame(4, 1);
            send_frame(4);
            compare("R1 R2 R3 R4 R5 sample");
        end

        // R6: full 256-channel frame of 2-bit slots, every third slot off.
        cfg_fall_edge = 0; cfg_sync_low = 0; cfg_sync_dly = 2'd1;
        cfg_lsb_first = 0; cfg_word_sel = 2'd0; cfg_last_chan = 8'd255;
        for (int c = 0; c < NCH; c++) chan_active[c] = (c % 3 != 1);
        do_reset();
        load_frame(256, 0);
        send_frame(256);
        compare("R6 R5 sample");

        // R9 and R10: offset wrap at 3 and threshold pulses at 1 and 0.
        cfg_fall_edge = 1; cfg_sync_low = 1; cfg_sync_dly = 2'd2;
        cfg_lsb_first = 1; cfg_word_sel = 2'd2; cfg_last_chan = 8'd0;
        chan_active = '0; chan_active[0] = 1'b1;
        cfg_buf_words = 16'd3; cfg_thr_a = 16'd1; cfg_thr_b = 16'd0;
        do_reset();
        for (int f = 0; f < 7; f++) begin
            load_frame(1, f % 3);
            send_frame(1);
        end
        compare("R9 sample");
        chk(irqa_n == 3, "R10 irq_a pulse cycles", irqa_n, 3);
        chk(irqb_n == 2, "R10 irq_b pulse cycles", irqb_n, 2);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run is counted as a failed check.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog all requirements actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule